// File: doc/BRIEF.md
# Fuse Array Burst Read Controller

This block sits between a register bus and an 8K-bit one-time-programmable fuse array organised as two halves of 512 byte locations each. Software first loads a timing register with two small cycle counts, then writes a command register carrying a half-select bit, a 9-bit start location, a byte count minus one and a start bit. The controller then walks the array one byte at a time. It drives the select, address and read strobe with the programmed timing and gathers up to 32 bytes into eight 32-bit buffer words.

When the burst ends, the start bit drops and a sticky done flag rises. If the interrupt enable is set, an interrupt line rises as well and stays high until software acknowledges the done flag. A burst that would run off the end of the selected half stops at its last location. Write and program control bits are stored and read back, but they start nothing.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq` and `fa_strobe` are low.
- R2: The command register is at byte offset 0x0: bit 30 is the half-select, bits 29:21 the start location, bits 20:16 the byte count minus one, bit 15 program enable, bit 1 write enable and bit 0 start. The timing register is at 0x4: bit 31 is interrupt enable, bits 23:20 setup count A, bits 19:16 strobe count S, bits 15:12 and 11:0 are write timings that are only stored. The other bits read as zero. Status is at 0x8, and buffer word w is at 0xC+4w.
- R3: A command write with bit 0 set starts a burst and clears done. A command write with bit 0 clear only records its fields and produces no strobe.
- R4: Each byte access lasts A+5+S cycles. The strobe is low for the first A+1 cycles and high for the remaining S+4.
- R5: Byte k of a burst is read from location start+k, with `fa_cs` equal to the half-select bit during the whole burst.
- R6: Byte k is stored in buffer word k/4 at bit lane 8*(k%4). Bytes not filled by the burst read as zero.
- R7: The burst length is the smaller of count+1 and 512−start.
- R8: At the end of the burst, command bit 0 reads 0 and status bit 0 (done) reads 1. Done stays set until a status write with bit 0 set. A status write with bit 0 clear has no effect, and status bit 1 reads 0.
- R9: With interrupt enable set, `irq` rises together with done and falls when done is acknowledged.
- R10: While a burst runs, writes to the command and timing registers are ignored.
- R11: If an acknowledge of done lands in the same cycle as the end of a burst, done and `irq` stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Burst-complete interrupt |
| fa_cs | output | 1 | Array half-select |
| fa_addr | output | 9 | Array byte location |
| fa_strobe | output | 1 | Array read strobe |
| fa_rdata | input | 8 | Array read data |

## Verification
Two actions can land in the same clock edge: the capture of the final byte, which sets done, and a software write that acknowledges done. The bench works out the exact cycle the burst ends from A, S and the clipped length, and times a status write so that it is captured on that edge. It then requires done and the interrupt to still be set. The same cycle arithmetic checks the strobe's first rise, the strobe-high count and the cycle done appears across a sweep of timing values, lengths and start locations, including bursts clipped at the top of a half.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
   localparam int FA_ADDR_W  = 9;
   localparam int BUF_WORDS  = 8;
   localparam int TADJ_W     = 4;
   localparam int TSTR_W     = 4;
   localparam int LEN_W      = 5;
   localparam logic [5:0] OFS_CMD  = 6'h00;
   localparam logic [5:0] OFS_TIM  = 6'h04;
   localparam logic [5:0] OFS_STAT = 6'h08;
   localparam logic [5:0] OFS_BUF0 = 6'h0C;
   localparam logic [31:0] TIM_MASK = 32'h80FF_FFFF;
endpackage

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
   parameter int ADDR_W = 9,
   parameter int NBYTES = 32,
   parameter int ADJ_W  = 4,
   parameter int STR_W  = 4,
   localparam int IDX_W = $clog2(NBYTES),
   localparam int CNT_W = ((ADJ_W > STR_W) ? ADJ_W : STR_W) + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADJ_W-1:0]  t_adj,
   input  logic [STR_W-1:0]  t_str,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [IDX_W:0]    nbytes,
   output logic              busy,
   output logic              strobe,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              cap,
   output logic [IDX_W-1:0]  cap_idx,
   output logic              finish
);
   logic [CNT_W-1:0]  cnt;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last;
   logic [ADDR_W-1:0] base;
   logic [CNT_W-1:0]  tlast;

   assign tlast    = CNT_W'(t_adj) + CNT_W'(t_str) + CNT_W'(4);
   assign cap      = busy && (cnt == tlast);
   assign finish   = cap && (idx == last);
   assign strobe   = busy && (cnt > CNT_W'(t_adj));
   assign cur_addr = base + ADDR_W'(idx);
   assign cap_idx  = idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         idx  <= '0;
         last <= '0;
         base <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
         idx  <= '0;
         last <= IDX_W'(nbytes - 1'b1);
         base <= base_in;
      end else if (busy) begin
         if (cnt == tlast) begin
            cnt <= '0;
            if (idx == last) busy <= 1'b0;
            else             idx  <= idx + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fuse_rd_buf.sv
module fuse_rd_buf #(
   parameter int NWORDS = 8,
   localparam int NBYTES = NWORDS * 4,
   localparam int IDX_W  = $clog2(NBYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  cap,
   input  logic [IDX_W-1:0]      cap_idx,
   input  logic [7:0]            cap_data,
   output logic [NWORDS*32-1:0]  words
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            lane_q <= '0;
         else if (cap && (cap_idx == IDX_W'(b)))
            lane_q <= cap_data;
      end
      assign words[b*8 +: 8] = lane_q;
   end
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
   import fuse_rd_pkg::*;
#(
   parameter int ADDR_W     = FA_ADDR_W,
   parameter int NWORDS     = BUF_WORDS,
   parameter int ADJ_W      = TADJ_W,
   parameter int STR_W      = TSTR_W,
   parameter bit IRQ_STICKY = 1'b1,
   localparam int NBYTES    = NWORDS * 4,
   localparam int IDX_W     = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [5:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              fa_cs,
   output logic [ADDR_W-1:0] fa_addr,
   output logic              fa_strobe,
   input  logic [7:0]        fa_rdata
);
   if (ADDR_W != 9 || NBYTES > (1 << LEN_W) || ADJ_W != 4 || STR_W != 4) begin : g_bad_cfg
      $error("fuse_rd_ctrl: parameters do not fit the register layout");
   end

   logic              cs_q, pg_q, wr_q, done_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [31:0]       tim_q;
   logic              busy, cap, finish, start;
   logic [IDX_W-1:0]  cap_idx;
   logic [NWORDS*32-1:0] words;
   logic              wr_cmd, wr_tim, ack;
   logic [LEN_W:0]    lenp1;
   logic [ADDR_W:0]   room;
   logic [IDX_W:0]    nbytes;

   assign wr_cmd = reg_we && (reg_addr == OFS_CMD) && !busy;
   assign wr_tim = reg_we && (reg_addr == OFS_TIM) && !busy;
   assign ack    = reg_we && (reg_addr == OFS_STAT) && reg_wdata[0];
   assign start  = wr_cmd && reg_wdata[0];

   assign lenp1  = {1'b0, reg_wdata[20:16]} + 1'b1;
   assign room   = (ADDR_W+1)'(1 << ADDR_W) - {1'b0, reg_wdata[29:21]};
   assign nbytes = (room < (ADDR_W+1)'(lenp1)) ? room[IDX_W:0] : IDX_W'(lenp1) + (IDX_W+1)'(0) + {lenp1[IDX_W], {IDX_W{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q   <= 1'b0;
         addr_q <= '0;
         len_q  <= '0;
         pg_q   <= 1'b0;
         wr_q   <= 1'b0;
         tim_q  <= '0;
      end else begin
         if (wr_cmd) begin
            cs_q   <= reg_wdata[30];
            addr_q <= reg_wdata[29:21];
            len_q  <= reg_wdata[20:16];
            pg_q   <= reg_wdata[15];
            wr_q   <= reg_wdata[1];
         end
         if (wr_tim) tim_q <= reg_wdata & TIM_MASK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      done_q <= 1'b0;
      else if (finish) done_q <= 1'b1;
      else if (start)  done_q <= 1'b0;
      else if (ack)    done_q <= 1'b0;
   end

   if (IRQ_STICKY) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                irq_q <= 1'b0;
         else if (finish && tim_q[31]) irq_q <= 1'b1;
         else if (ack || start)     irq_q <= 1'b0;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = done_q && tim_q[31];
   end

   fuse_rd_seq #(
      .ADDR_W(ADDR_W), .NBYTES(NBYTES), .ADJ_W(ADJ_W), .STR_W(STR_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .t_adj(tim_q[23:20]), .t_str(tim_q[19:16]),
      .base_in(reg_wdata[29:21]), .nbytes(nbytes),
      .busy(busy), .strobe(fa_strobe), .cur_addr(fa_addr),
      .cap(cap), .cap_idx(cap_idx), .finish(finish)
   );

   fuse_rd_buf #(.NWORDS(NWORDS)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(start), .cap(cap),
      .cap_idx(cap_idx), .cap_data(fa_rdata), .words(words)
   );

   assign fa_cs = busy && cs_q;

   logic [5:0] wsel;
   assign wsel = reg_addr - OFS_BUF0;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_CMD)
         reg_rdata = {1'b0, cs_q, addr_q, len_q, pg_q, 13'b0, wr_q, busy};
      else if (reg_addr == OFS_TIM)
         reg_rdata = tim_q;
      else if (reg_addr == OFS_STAT)
         reg_rdata = {30'b0, 1'b0, done_q};
      else if (reg_addr >= OFS_BUF0 && wsel[5:2] < 4'(NWORDS) && wsel[1:0] == 2'b00)
         reg_rdata = words[wsel[5:2]*32 +: 32];
   end
endmodule

// File: rtl/fuse_rd_chk.sv
module fuse_rd_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        fa_strobe,
   input logic [8:0]  fa_addr,
   input logic        fa_cs,
   input logic        done,
   input logic        irq,
   input logic [31:0] tim
);
   AST_STROBE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      fa_strobe |-> busy); // R4
   AST_ADDR_HOLD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (fa_strobe && $past(fa_strobe)) |-> ($stable(fa_addr) && $stable(fa_cs))); // R5
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8
   AST_TIM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(tim)); // R10
   AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done); // R9
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !done); // R3
endmodule

bind fuse_rd_ctrl fuse_rd_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .fa_strobe(fa_strobe),
   .fa_addr(fa_addr), .fa_cs(fa_cs), .done(done_q), .irq(irq), .tim(tim_q)
);

// File: tb/fuse_rd_ctrl_bench.sv
module fuse_rd_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [5:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic irq, fa_cs, fa_strobe;
   logic [8:0] fa_addr;
   logic [7:0] fa_rdata;
   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   function automatic logic [7:0] fuse_val(input logic cs, input int a);
      return 8'((a * 29 + (cs ? 101 : 0) + 7) & 255);
   endfunction
   assign fa_rdata = fuse_val(fa_cs, int'(fa_addr));

   fuse_rd_ctrl u_fuse_rd_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .fa_cs(fa_cs), .fa_addr(fa_addr), .fa_strobe(fa_strobe), .fa_rdata(fa_rdata)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic run(input logic cs, input int addr, input int len, input int adj,
                      input int str, input bit poke_busy, input bit ack_at_end);
      int tper, n, k, strobes, first, bad_addr, rel;
      logic [31:0] d, cfg;
      tper = adj + 5 + str;
      n = (len + 1 < 512 - addr) ? len + 1 : 512 - addr;
      cfg = 32'h8000_0000 | (32'(adj) << 20) | (32'(str) << 16) | 32'h0000_5ABC;
      wr(6'h04, cfg);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'h00;
      reg_wdata = {1'b0, cs, 9'(addr), 5'(len), 16'h0001};
      strobes = 0; first = -1; bad_addr = 0; k = 0;
      forever begin
         @(negedge clk);
         reg_we = 1'b0;
         if (poke_busy && k == 1) begin reg_we = 1'b1; reg_addr = 6'h04; reg_wdata = 32'h0; end
         if (poke_busy && k == 2) begin reg_we = 1'b1; reg_addr = 6'h00; reg_wdata = 32'h4000_0001; end
         if (ack_at_end && k == n * tper - 1) begin reg_we = 1'b1; reg_addr = 6'h08; reg_wdata = 32'h1; end
         if (!reg_we) begin
            rd(6'h08, d);
            if (d[0]) break;
         end
         if (fa_strobe) begin
            strobes++;
            if (first < 0) first = k;
         end
         rel = k / tper;
         if (rel < n && (int'(fa_addr) != addr + rel || fa_cs != cs)) bad_addr++;
         k++;
         if (k > 40000) break;
      end
      if (ack_at_end) begin
         @(negedge clk);
         reg_we = 1'b0;
         rd(6'h08, d);
         chk(d[0] == 1'b1, "R11 done kept", d[0], 1);
         chk(irq == 1'b1, "R11 irq kept", irq, 1);
      end else begin
         chk(k == n * tper, "R4 burst cycles", k, n * tper);
         chk(strobes == n * (str + 4), "R4 strobe cycles", strobes, n * (str + 4));
         chk(first == adj + 1, "R4 setup before strobe", first, adj + 1);
         chk(bad_addr == 0, "R5 R7 address sequence", bad_addr, 0);
         chk(irq == 1'b1, "R9 irq on done", irq, 1);
      end
      rd(6'h00, d);
      chk(d == {1'b0, cs, 9'(addr), 5'(len), 16'h0000}, "R8 R10 cmd readback", d,
          {1'b0, cs, 9'(addr), 5'(len), 16'h0000});
      rd(6'h04, d);
      chk(d == (cfg & 32'h80FF_FFFF), "R10 R2 timing readback", d, cfg & 32'h80FF_FFFF);
      for (int w = 0; w < 8; w++) begin
         logic [31:0] e;
         for (int b = 0; b < 4; b++) begin
            int kk = w * 4 + b;
            e[b*8 +: 8] = (kk < n) ? fuse_val(cs, addr + kk) : 8'h00;
         end
         rd(6'(12 + 4 * w), d);
         chk(d == e, "R6 R7 buffer word", d, e);
      end
      wr(6'h08, 32'h0);
      rd(6'h08, d);
      chk(d == 32'h1, "R8 zero write no effect", d, 1);
      wr(6'h08, 32'h1);
      rd(6'h08, d);
      chk(d == 32'h0 && irq == 1'b0, "R8 R9 ack clears", {d, 31'b0, irq}, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int adjs[3], strs[3];
      adjs = '{0, 2, 15};
      strs = '{0, 7, 15};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 48; a += 4) begin
         rd(6'(a), d);
         chk(d == 32'h0, "R1 reset register", d, 0);
      end
      chk(irq == 1'b0 && fa_strobe == 1'b0, "R1 reset outputs", {irq, fa_strobe}, 0);
      wr(6'h04, 32'hFFFF_FFFF);
      rd(6'h04, d);
      chk(d == 32'h80FF_FFFF, "R2 timing mask", d, 32'h80FF_FFFF);
      wr(6'h00, 32'hFFFF_FFFE);
      rd(6'h00, d);
      chk(d == 32'h7FFF_8002, "R2 R3 cmd fields stored", d, 32'h7FFF_8002);
      repeat (5) @(negedge clk);
      chk(fa_strobe == 1'b0, "R3 no start without bit0", fa_strobe, 0);
      rd(6'h08, d);
      chk(d == 32'h0, "R3 no done without bit0", d, 0);
      for (int i = 0; i < 3; i++)
         for (int j = 0; j < 3; j++)
            run(1'((i ^ j) & 1), (adjs[i] * 37 + strs[j] * 11) % 500,
                (adjs[i] + strs[j] + i) % 32, adjs[i], strs[j], 1'b0, 1'b0);
      run(1'b1, 510, 31, 1, 2, 1'b0, 1'b0);   // R7 clipped to 2 bytes
      run(1'b0, 511, 0, 0, 0, 1'b0, 1'b0);    // R7 single last byte
      run(1'b0, 0, 31, 3, 1, 1'b1, 1'b0);     // R10 writes while busy
      run(1'b1, 100, 5, 2, 3, 1'b0, 1'b1);    // R11 ack on completion edge
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule